// File: doc/BRIEF.md
# Three-Wire Nibble Register Transfer Engine

This block is a serial master for a small clock chip that sits on a three-wire bus. The bus has a clock line that idles high and a single bidirectional data line. The block frames every access out of 8-bit command bytes and sends each byte most-significant bit first. When it receives, it shifts a response byte in from the same data line. Chip-enable handling and the meaning of the chip's registers are left to the surrounding logic.

A client starts an access with a one-cycle start request. It supplies a direction flag, a 4-bit register address and, for writes, a 4-bit data value. The engine raises busy until the access ends, then gives a one-cycle done pulse.

- A read sends one command byte that carries the address, the read flag and the address flag. After a one-half-period turnaround it clocks in a byte, and the low nibble of that byte is returned.
- A write sends an address command byte, then a data command byte that carries the nibble and the data flag.

Bit timing comes from a half-period counter. Its length is worked out from the system clock period and rounded up, so the half-period is never shorter than 700 ns. The incoming data line passes through a two-flop synchroniser. The received bit is taken in the last system cycle of the clock-high phase, so the synchroniser delay still falls within that phase.

Top module: `nibble_bus_master`

## Requirements
- R1: Out of reset and whenever idle, the clock line is high, the data output enable is low, busy is low and done is low; the read result resets to 0.
- R2: Every transmitted byte is 8 bits long and is sent most-significant bit first.
- R3: For each transmitted bit, the bit value is placed on the data line with the clock high for one half-period. The clock is then low for one half-period and returns high. The data output does not change while the clock is low.
- R4: The half-period is ceil(MIN_HALF_PS / CLK_PERIOD_PS) system cycles, which is 175 cycles at the default 4000 ps period and 700000 ps minimum. Every clock-low phase lasts exactly that many cycles.
- R5: The data output enable is high while a command byte is sent, from its first bit until the rising clock that ends its eighth bit. It is low during the one-half-period turnaround (clock high) between two bytes and during the whole receive byte, so a read asserts it once and a write twice.
- R6: A read command byte equals the address OR 0x60: bit 6 is the read flag, bit 5 is the address flag, bit 4 is 0 and bits 3:0 carry the address.
- R7: Each received bit is taken from the synchronised data input in the last cycle of the clock-high phase, before the falling edge. A device that changes its data at each falling edge is therefore read correctly.
- R8: The read result is the low nibble of the received byte, assembled most-significant bit first, and it is valid from the done pulse.
- R9: A write sends the address OR 0x20 first, then the data nibble OR 0x10, where bit 4 is the data flag.
- R10: Every access lasts 33 half-periods: 16 for the first byte, 1 for the turnaround and 16 for the second byte. Busy is high for exactly that many cycles.
- R11: A start request while busy is ignored. The running access completes unchanged, and no second access follows.
- R12: Done is high for exactly one cycle, in the cycle in which busy has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin an access |
| write_i | input | 1 | 1 for register write, 0 for register read |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Nibble to write |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 4 | Nibble returned by the last read |
| sclk_o | output | 1 | Bus clock, idles high |
| sdat_o | output | 1 | Data line output value |
| sdat_oe_o | output | 1 | Data line output enable |
| sdat_i | input | 1 | Data line input value |

## Verification
The hardest point to reach from the ports is where a received bit is sampled. Sampling it one cycle after the falling edge instead of before it yields plausible data whenever neighbouring bits are equal. The bench therefore uses a device model that moves to its next bit at every falling clock edge. It returns bytes with alternating bit patterns and non-zero upper nibbles, so a late sample, a missed synchroniser stage or a leaked high nibble each shows up in the returned value. A second start request is injected halfway through a write to confirm that it leaves the frame, the duration and the done count untouched.

// File: rtl/nbm_pkg.sv
package nbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_GAP  = 2'd2,
    ST_RX   = 2'd3
  } nbm_state_e;

  // Half-period in system cycles, rounded up so it never undercuts the minimum.
  function automatic int unsigned half_cycles(input int unsigned period_ps,
                                              input int unsigned min_ps);
    return (min_ps + period_ps - 1) / period_ps;
  endfunction

  // Read command: read flag (bit 6) and address flag (bit 5) with the address.
  function automatic logic [7:0] read_cmd(input logic [3:0] addr);
    return {4'b0110, addr};
  endfunction

  // Write address command: address flag (bit 5) with the address.
  function automatic logic [7:0] write_addr_cmd(input logic [3:0] addr);
    return {4'b0010, addr};
  endfunction

  // Write data command: data flag (bit 4) with the nibble.
  function automatic logic [7:0] write_data_cmd(input logic [3:0] nib);
    return {4'b0001, nib};
  endfunction

endpackage

// File: rtl/nbm_sync2.sv
module nbm_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nbm_half_timer.sv
module nbm_half_timer #(
  parameter int unsigned HALF = 175,
  parameter int unsigned CW   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic half_end
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= CW'(HALF - 1);
    else if (restart)     cnt <= CW'(HALF - 1);
    else if (run)         cnt <= (cnt == '0) ? CW'(HALF - 1) : cnt - 1'b1;
  end

  assign half_end = run && !restart && (cnt == '0);
endmodule

// File: rtl/nibble_bus_master.sv
module nibble_bus_master #(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned MIN_HALF_PS   = 700000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       write_i,
  input  logic [3:0] addr_i,
  input  logic [3:0] wdata_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [3:0] rdata_o,
  output logic       sclk_o,
  output logic       sdat_o,
  output logic       sdat_oe_o,
  input  logic       sdat_i
);
  import nbm_pkg::*;

  localparam int unsigned HALF = half_cycles(CLK_PERIOD_PS, MIN_HALF_PS);
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  nbm_state_e state;
  logic [7:0] tx_sh, rx_sh, second_cmd;
  logic [2:0] bit_idx;
  logic       low_phase, byte_no, is_write;
  logic       sdat_sync;

  // Named internal events for the checker.
  logic accept, half_end, rx_active, last_bit;
  assign accept    = start_i && (state == ST_IDLE);
  assign rx_active = (state == ST_RX);
  assign last_bit  = (bit_idx == 3'd7) && low_phase;

  nbm_sync2 u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sdat_i),
    .q     (sdat_sync)
  );

  nbm_half_timer #(.HALF(HALF), .CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (accept),
    .run      (busy_o),
    .half_end (half_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tx_sh      <= '0;
      rx_sh      <= '0;
      second_cmd <= '0;
      bit_idx    <= '0;
      low_phase  <= 1'b0;
      byte_no    <= 1'b0;
      is_write   <= 1'b0;
      done_o     <= 1'b0;
      rdata_o    <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state      <= ST_TX;
          is_write   <= write_i;
          tx_sh      <= write_i ? write_addr_cmd(addr_i) : read_cmd(addr_i);
          second_cmd <= write_data_cmd(wdata_i);
          bit_idx    <= '0;
          low_phase  <= 1'b0;
          byte_no    <= 1'b0;
        end
        ST_TX: if (half_end) begin
          if (!low_phase) begin
            low_phase <= 1'b1;
          end else begin
            low_phase <= 1'b0;
            if (last_bit) begin
              if (byte_no) begin
                state  <= ST_IDLE;
                done_o <= 1'b1;
              end else begin
                state <= ST_GAP;
              end
            end else begin
              bit_idx <= bit_idx + 1'b1;
              tx_sh   <= {tx_sh[6:0], 1'b0};
            end
          end
        end
        ST_GAP: if (half_end) begin
          byte_no <= 1'b1;
          bit_idx <= '0;
          if (is_write) begin
            tx_sh <= second_cmd;
            state <= ST_TX;
          end else begin
            state <= ST_RX;
          end
        end
        ST_RX: if (half_end) begin
          if (!low_phase) begin
            rx_sh     <= {rx_sh[6:0], sdat_sync};
            low_phase <= 1'b1;
          end else begin
            low_phase <= 1'b0;
            if (last_bit) begin
              state   <= ST_IDLE;
              done_o  <= 1'b1;
              rdata_o <= rx_sh[3:0];
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state != ST_IDLE);
  assign sclk_o    = !(low_phase && (state == ST_TX || state == ST_RX));
  assign sdat_oe_o = (state == ST_TX);
  assign sdat_o    = (state == ST_TX) ? tx_sh[7] : 1'b0;

endmodule

// File: rtl/nbm_checker.sv
module nbm_checker #(
  parameter int unsigned HALF = 175,
  parameter int unsigned CW   = 8
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic sdat,
  input logic oe,
  input logic rx_active,
  input logic half_end
);
  logic [CW:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lo_cnt <= '0;
    else if (sclk) lo_cnt <= '0;
    else           lo_cnt <= lo_cnt + 1'b1;
  end

  // R1: idle bus state
  p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk && !oe));

  // R3: transmitted data held while the clock is low
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !sclk && $past(oe) && !$past(sclk)) |-> $stable(sdat));

  // R4: each clock-low phase lasts one half-period
  p_low_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (lo_cnt == (CW+1)'(HALF)));

  // R4: timer events only while an access runs
  p_tick_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    half_end |-> busy);

  // R5: output enable never on while receiving
  p_no_drive_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |-> !oe);

  // R12: done is a single-cycle pulse
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: done marks the end of busy
  p_done_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind nibble_bus_master nbm_checker #(.HALF(HALF), .CW(CW)) u_nbm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy_o),
  .done      (done_o),
  .sclk      (sclk_o),
  .sdat      (sdat_o),
  .oe        (sdat_oe_o),
  .rx_active (rx_active),
  .half_end  (half_end)
);

// File: tb/nibble_bus_master_test.sv
`timescale 1ns/1ps
module nibble_bus_master_test;
  localparam int HALF_EXP = (700000 + 4000 - 1) / 4000;  // 175 cycles
  localparam int ACC_CYC  = 33 * HALF_EXP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, write_i = 1'b0;
  logic [3:0] addr_i = '0, wdata_i = '0;
  logic busy_o, done_o, sclk_o, sdat_o, sdat_oe_o, sdat_i;
  logic [3:0] rdata_o;

  always #2 clk = ~clk;

  nibble_bus_master uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o),
    .rdata_o(rdata_o), .sclk_o(sclk_o), .sdat_o(sdat_o),
    .sdat_oe_o(sdat_oe_o), .sdat_i(sdat_i)
  );

  int checks = 0, errors = 0;

  // Bus monitor and device model state
  logic [7:0] dev_byte = '0;
  int rx_idx = 7;
  logic prev_sclk = 1'b1, prev_oe = 1'b0;
  logic [7:0] cur = '0;
  logic [7:0] got [0:3];
  int tx_bits = 0, rx_falls = 0, oe_rises = 0, busy_cyc = 0, done_cnt = 0;
  int lo_run = 0, lo_min = 1 << 30, lo_max = 0;

  assign sdat_i = (rx_idx >= 0) ? dev_byte[rx_idx[2:0]] : 1'b0;

  always @(negedge clk) begin
    if (busy_o) busy_cyc++;
    if (done_o) done_cnt++;
    if (sdat_oe_o && !prev_oe) oe_rises++;
    if (prev_sclk && !sclk_o) begin
      if (sdat_oe_o) begin
        cur = {cur[6:0], sdat_o};
        tx_bits++;
        if (tx_bits % 8 == 0 && tx_bits <= 32) got[tx_bits/8 - 1] = cur;
      end else begin
        rx_falls++;
        rx_idx--;
      end
    end
    if (!sclk_o) lo_run++;
    else if (!prev_sclk) begin
      if (lo_run < lo_min) lo_min = lo_run;
      if (lo_run > lo_max) lo_max = lo_run;
      lo_run = 0;
    end
    prev_sclk = sclk_o;
    prev_oe   = sdat_oe_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    tx_bits = 0; rx_falls = 0; oe_rises = 0; busy_cyc = 0; done_cnt = 0;
    lo_min = 1 << 30; lo_max = 0; rx_idx = 7;
    for (int i = 0; i < 4; i++) got[i] = '0;
  endtask

  task automatic launch(input logic wr, input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    clear_mon();
    start_i = 1'b1; write_i = wr; addr_i = a; wdata_i = d;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (done_cnt == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic common_checks(input int n_oe);
    chk("R10 busy cycles", 32'(busy_cyc), 32'(ACC_CYC));
    chk("R12 done pulses", 32'(done_cnt), 32'd1);
    chk("R4 min low phase", 32'(lo_min), 32'(HALF_EXP));
    chk("R4 max low phase", 32'(lo_max), 32'(HALF_EXP));
    chk("R5 oe assertions", 32'(oe_rises), 32'(n_oe));
    chk("R1 idle after access", {29'd0, sclk_o, sdat_oe_o, busy_o}, 32'b100);
  endtask

  task automatic test_reset();
    chk("R1 reset sclk", 32'(sclk_o), 32'd1);
    chk("R1 reset oe", 32'(sdat_oe_o), 32'd0);
    chk("R1 reset busy/done", {30'd0, busy_o, done_o}, 32'd0);
    chk("R1 reset rdata", 32'(rdata_o), 32'd0);
  endtask

  task automatic test_write(input logic [3:0] a, input logic [3:0] d);
    dev_byte = '0;
    launch(1'b1, a, d);
    wait_done();
    chk("R2 R3 write bit count", 32'(tx_bits), 32'd16);
    chk("R9 address byte", 32'(got[0]), 32'({4'h2, a}));
    chk("R9 data byte", 32'(got[1]), 32'({4'h1, d}));
    common_checks(2);
  endtask

  task automatic test_read(input logic [3:0] a, input logic [7:0] resp);
    dev_byte = resp;
    launch(1'b0, a, 4'h0);
    wait_done();
    chk("R2 R6 read cmd bits", 32'(tx_bits), 32'd8);
    chk("R6 read command", 32'(got[0]), 32'({4'h6, a}));
    chk("R7 receive falls", 32'(rx_falls), 32'd8);
    chk("R7 R8 read nibble", 32'(rdata_o), 32'(resp[3:0]));
    common_checks(1);
  endtask

  task automatic test_start_ignored();
    dev_byte = '0;
    launch(1'b1, 4'h2, 4'h6);
    repeat (1000) @(negedge clk);
    start_i = 1'b1; write_i = 1'b0; addr_i = 4'h9;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    repeat (2 * HALF_EXP) @(negedge clk);
    chk("R11 first byte kept", 32'(got[0]), 32'h22);
    chk("R11 second byte kept", 32'(got[1]), 32'h16);
    chk("R11 no extra bits", 32'(tx_bits), 32'd16);
    chk("R11 single done", 32'(done_cnt), 32'd1);
    chk("R11 duration", 32'(busy_cyc), 32'(ACC_CYC));
    chk("R11 idle afterwards", 32'(busy_o), 32'd0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_write(4'h3, 4'h9);
    test_write(4'hF, 4'h0);
    test_read(4'hE, 8'hA5);
    test_read(4'h0, 8'h5A);
    test_read(4'h7, 8'hF3);
    test_start_ignored();
    finish_run();
  end
endmodule